// File: doc/BRIEF.md
# Merged Register File Rename Controller

This block keeps the bookkeeping for a register file in which architectural values and renamed results share one pool of physical registers. Every physical register is always in one of four lifecycle states. A speculative mapping table tells which physical register currently stands for each architectural register, and a committed copy of that table holds the in-order architectural view. The block stores tags and states only. Operand values live in a separate data array that is addressed with the indices this block hands out.

An issue port takes a destination architectural register and returns a freshly allocated physical index, together with the index that index replaces. Source lookup ports rename source operands. A finish port marks a result as written. A complete port, used strictly in program order, turns the register into the architectural copy without moving any data and reclaims the instance it displaced. A flush returns every uncommitted allocation to the pool and rolls the speculative table back to the committed one.

Top module: `rn_merged_ctrl`

## Requirements
- R1: After reset, physical register a (for a below NUM_ARCH) is the architectural copy of architectural register a and reads state 1. Every other physical register reads state 0. Every lookup of a returns a with its renamed flag clear. State codes: 0 available, 1 architectural, 2 allocated with result pending, 3 allocated with result written.
- R2: When issue_valid_i and issue_ready_o are both high at a clock edge, the lowest-numbered available physical register is allocated. Its index is shown on issue_phys_o during that cycle, and it reads state 2 afterwards. issue_old_phys_o always shows the current speculative mapping of issue_arch_i.
- R3: issue_ready_o is low whenever no physical register is available or flush_i is high. An issue request while it is low changes no state and no mapping.
- R4: Each source port returns the speculative mapping of its architectural register. In the cycle of an allocation to that same register it returns the mapping from before the allocation, and from the next cycle on it returns the new index.
- R5: A finish on a register in state 2 moves it to state 3. A finish on a register in any other state has no effect.
- R6: A complete on a register in state 3 moves it to state 1 and makes it the committed mapping of its destination. The physical register that was mapped to that destination when the register was allocated returns to state 0.
- R7: A flush moves every register in state 2 or 3 to state 0 and restores all speculative mappings to the committed mappings. A flush overrides any issue, finish or complete in the same cycle.
- R8: The renamed flag of an architectural register is set by an allocation to it. It is cleared when its newest instance completes, or on a flush.
- R9: Exactly NUM_ARCH physical registers are in state 1 at every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_valid_i | input | 1 | Allocation request |
| issue_arch_i | input | AW | Destination architectural register |
| issue_ready_o | output | 1 | A register can be allocated this cycle |
| issue_phys_o | output | PW | Index that an accepted request receives |
| issue_old_phys_o | output | PW | Current mapping of issue_arch_i |
| src_arch_i | input | NUM_SRC*AW | Packed source architectural registers |
| src_phys_o | output | NUM_SRC*PW | Packed mapped physical indices |
| src_renamed_o | output | NUM_SRC | Renamed flag per source port |
| finish_valid_i | input | 1 | Result written strobe |
| finish_phys_i | input | PW | Register whose result was written |
| complete_valid_i | input | 1 | In-order completion strobe |
| complete_phys_i | input | PW | Register being completed |
| flush_i | input | 1 | Cancel all uncommitted allocations |
| query_phys_i | input | PW | Register whose state is read |
| query_state_o | output | 2 | Lifecycle state of query_phys_i |

## Verification
The bench looks at lookups taken in the same cycle as an allocation to the same register. A design that forwards the new index there would break the in-flight instruction's source dependency. It fills the pool until the issue port stalls, then presses issue anyway. A design that ignores ready would corrupt a register that is still live. It finishes registers that are architectural or already free, which a loose finish decode would turn into phantom pending results. It completes registers and then checks that the displaced instance, and only that one, becomes available. It also flushes under a random mix of traffic and compares every state and mapping with the committed view. A design that kept speculative mappings after a flush would hand out indices that point at freed registers.

// File: rtl/rn_pkg.sv
package rn_pkg;
  typedef enum logic [1:0] {
    PR_FREE = 2'd0,
    PR_ARCH = 2'd1,
    PR_PEND = 2'd2,
    PR_DONE = 2'd3
  } preg_state_e;
endpackage

// File: rtl/rn_free_pick.sv
module rn_free_pick #(
  parameter int NUM_PHYS = 16,
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic [NUM_PHYS-1:0] free_vec_i,
  output logic                any_o,
  output logic [PW-1:0]       idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (free_vec_i[i]) idx_o = PW'(i);
    end
  end
  assign any_o = |free_vec_i;
endmodule

// File: rtl/rn_phys_state.sv
module rn_phys_state
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                flush_i,
  input  logic                alloc_en_i,
  input  logic [PW-1:0]       alloc_idx_i,
  input  logic [AW-1:0]       alloc_dest_i,
  input  logic [PW-1:0]       alloc_prev_i,
  input  logic                fin_en_i,
  input  logic [PW-1:0]       fin_idx_i,
  input  logic                cmt_en_i,
  input  logic [PW-1:0]       cmt_idx_i,
  input  logic [PW-1:0]       query_idx_i,
  output logic [NUM_PHYS-1:0] free_vec_o,
  output logic [AW-1:0]       cmt_dest_o,
  output logic [PW-1:0]       cmt_prev_o,
  output logic [1:0]          query_state_o
);
  preg_state_e st_q   [NUM_PHYS];
  logic [AW-1:0] dest_q [NUM_PHYS];
  logic [PW-1:0] prev_q [NUM_PHYS];

  logic [NUM_PHYS-1:0] arch_vec, pend_vec, done_vec;

  assign cmt_dest_o    = dest_q[cmt_idx_i];
  assign cmt_prev_o    = prev_q[cmt_idx_i];
  assign query_state_o = st_q[query_idx_i];

  always_comb begin
    for (int p = 0; p < NUM_PHYS; p++) begin
      free_vec_o[p] = (st_q[p] == PR_FREE);
      arch_vec[p]   = (st_q[p] == PR_ARCH);
      pend_vec[p]   = (st_q[p] == PR_PEND);
      done_vec[p]   = (st_q[p] == PR_DONE);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PHYS; p++) begin
        st_q[p]   <= (p < NUM_ARCH) ? PR_ARCH : PR_FREE;
        dest_q[p] <= '0;
        prev_q[p] <= '0;
      end
    end else if (flush_i) begin
      for (int p = 0; p < NUM_PHYS; p++) begin
        if (st_q[p] == PR_PEND || st_q[p] == PR_DONE) st_q[p] <= PR_FREE;
      end
    end else begin
      for (int p = 0; p < NUM_PHYS; p++) begin
        if (alloc_en_i && alloc_idx_i == PW'(p)) begin
          st_q[p]   <= PR_PEND;
          dest_q[p] <= alloc_dest_i;
          prev_q[p] <= alloc_prev_i;
        end else if (fin_en_i && fin_idx_i == PW'(p) && st_q[p] == PR_PEND) begin
          st_q[p] <= PR_DONE;
        end else if (cmt_en_i && cmt_idx_i == PW'(p)) begin
          st_q[p] <= PR_ARCH;
        end else if (cmt_en_i && cmt_prev_o == PW'(p)) begin
          st_q[p] <= PR_FREE;
        end
      end
    end
  end

  assert_arch_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(arch_vec) == NUM_ARCH);

  assert_flush_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (pend_vec == '0) && (done_vec == '0));

  assert_alloc_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |-> st_q[alloc_idx_i] == PR_FREE);

  assert_alloc_pend_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_en_i && !flush_i) |=> st_q[$past(alloc_idx_i)] == PR_PEND);

  assert_finish_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_en_i && !flush_i && st_q[fin_idx_i] == PR_PEND)
      |=> st_q[$past(fin_idx_i)] == PR_DONE);

  assert_commit_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_en_i && !flush_i) |-> st_q[cmt_idx_i] == PR_DONE);

  assert_commit_result_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmt_en_i && !flush_i)
      |=> (st_q[$past(cmt_idx_i)] == PR_ARCH) && (st_q[$past(cmt_prev_o)] == PR_FREE));
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_SRC  = 2,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  alloc_en_i,
  input  logic [AW-1:0]         alloc_arch_i,
  input  logic [PW-1:0]         alloc_idx_i,
  output logic [PW-1:0]         alloc_old_o,
  input  logic                  cmt_en_i,
  input  logic [AW-1:0]         cmt_arch_i,
  input  logic [PW-1:0]         cmt_idx_i,
  input  logic [NUM_SRC*AW-1:0] src_arch_i,
  output logic [NUM_SRC*PW-1:0] src_phys_o,
  output logic [NUM_SRC-1:0]    src_renamed_o
);
  logic [PW-1:0] spec_q   [NUM_ARCH];
  logic [PW-1:0] commit_q [NUM_ARCH];
  logic [NUM_ARCH-1:0] ren_q;

  assign alloc_old_o = spec_q[alloc_arch_i];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic [AW-1:0] a;
    assign a = src_arch_i[s*AW +: AW];
    assign src_phys_o[s*PW +: PW] = spec_q[a];
    assign src_renamed_o[s]       = ren_q[a];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int a = 0; a < NUM_ARCH; a++) begin
        spec_q[a]   <= PW'(a);
        commit_q[a] <= PW'(a);
      end
      ren_q <= '0;
    end else if (flush_i) begin
      for (int a = 0; a < NUM_ARCH; a++) spec_q[a] <= commit_q[a];
      ren_q <= '0;
    end else begin
      if (cmt_en_i) begin
        commit_q[cmt_arch_i] <= cmt_idx_i;
        if (spec_q[cmt_arch_i] == cmt_idx_i) ren_q[cmt_arch_i] <= 1'b0;
      end
      if (alloc_en_i) begin
        spec_q[alloc_arch_i] <= alloc_idx_i;
        ren_q[alloc_arch_i]  <= 1'b1;
      end
    end
  end

  assert_alloc_maps_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_en_i && !flush_i)
      |=> (spec_q[$past(alloc_arch_i)] == $past(alloc_idx_i)) && ren_q[$past(alloc_arch_i)]);

  assert_flush_unrenamed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> ren_q == '0);
endmodule

// File: rtl/rn_merged_ctrl.sv
module rn_merged_ctrl
  import rn_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int NUM_PHYS = 16,
  parameter int NUM_SRC  = 2,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int PW = $clog2(NUM_PHYS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  issue_valid_i,
  input  logic [AW-1:0]         issue_arch_i,
  output logic                  issue_ready_o,
  output logic [PW-1:0]         issue_phys_o,
  output logic [PW-1:0]         issue_old_phys_o,
  input  logic [NUM_SRC*AW-1:0] src_arch_i,
  output logic [NUM_SRC*PW-1:0] src_phys_o,
  output logic [NUM_SRC-1:0]    src_renamed_o,
  input  logic                  finish_valid_i,
  input  logic [PW-1:0]         finish_phys_i,
  input  logic                  complete_valid_i,
  input  logic [PW-1:0]         complete_phys_i,
  input  logic                  flush_i,
  input  logic [PW-1:0]         query_phys_i,
  output logic [1:0]            query_state_o
);
  logic [NUM_PHYS-1:0] free_vec;
  logic                any_free;
  logic                alloc_en;
  logic [AW-1:0]       cmt_dest;
  logic [PW-1:0]       cmt_prev;

  assign issue_ready_o = any_free && !flush_i;
  assign alloc_en      = issue_valid_i && issue_ready_o;

  rn_free_pick #(.NUM_PHYS(NUM_PHYS)) u_pick (
    .free_vec_i (free_vec),
    .any_o      (any_free),
    .idx_o      (issue_phys_o)
  );

  rn_phys_state #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_state (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .alloc_en_i    (alloc_en),
    .alloc_idx_i   (issue_phys_o),
    .alloc_dest_i  (issue_arch_i),
    .alloc_prev_i  (issue_old_phys_o),
    .fin_en_i      (finish_valid_i),
    .fin_idx_i     (finish_phys_i),
    .cmt_en_i      (complete_valid_i),
    .cmt_idx_i     (complete_phys_i),
    .query_idx_i   (query_phys_i),
    .free_vec_o    (free_vec),
    .cmt_dest_o    (cmt_dest),
    .cmt_prev_o    (cmt_prev),
    .query_state_o (query_state_o)
  );

  rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_SRC(NUM_SRC)) u_map (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .flush_i       (flush_i),
    .alloc_en_i    (alloc_en),
    .alloc_arch_i  (issue_arch_i),
    .alloc_idx_i   (issue_phys_o),
    .alloc_old_o   (issue_old_phys_o),
    .cmt_en_i      (complete_valid_i),
    .cmt_arch_i    (cmt_dest),
    .cmt_idx_i     (complete_phys_i),
    .src_arch_i    (src_arch_i),
    .src_phys_o    (src_phys_o),
    .src_renamed_o (src_renamed_o)
  );

  assert_stall_empty_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (free_vec == '0) |-> !issue_ready_o);

  assert_stall_no_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!issue_ready_o && !complete_valid_i) |=> $stable(free_vec) || $past(flush_i));
endmodule

// File: tb/rn_merged_ctrl_tb.sv
module rn_merged_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8;
  localparam int NP = 16;
  localparam int NS = 2;
  localparam int AW = $clog2(NA);
  localparam int PW = $clog2(NP);
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_valid_i = 1'b0;
  logic [AW-1:0] issue_arch_i = '0;
  logic issue_ready_o;
  logic [PW-1:0] issue_phys_o, issue_old_phys_o;
  logic [NS*AW-1:0] src_arch_i = '0;
  logic [NS*PW-1:0] src_phys_o;
  logic [NS-1:0] src_renamed_o;
  logic finish_valid_i = 1'b0;
  logic [PW-1:0] finish_phys_i = '0;
  logic complete_valid_i = 1'b0;
  logic [PW-1:0] complete_phys_i = '0;
  logic flush_i = 1'b0;
  logic [PW-1:0] query_phys_i = '0;
  logic [1:0] query_state_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  rn_merged_ctrl #(.NUM_ARCH(NA), .NUM_PHYS(NP), .NUM_SRC(NS)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .issue_valid_i(issue_valid_i), .issue_arch_i(issue_arch_i),
    .issue_ready_o(issue_ready_o), .issue_phys_o(issue_phys_o),
    .issue_old_phys_o(issue_old_phys_o),
    .src_arch_i(src_arch_i), .src_phys_o(src_phys_o), .src_renamed_o(src_renamed_o),
    .finish_valid_i(finish_valid_i), .finish_phys_i(finish_phys_i),
    .complete_valid_i(complete_valid_i), .complete_phys_i(complete_phys_i),
    .flush_i(flush_i), .query_phys_i(query_phys_i), .query_state_o(query_state_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model
  int m_st [NP];
  int m_dest [NP];
  int m_prev [NP];
  int m_spec [NA];
  int m_cmt [NA];
  bit m_ren [NA];
  int fifo [NP];
  int f_cnt = 0;

  function automatic int pick_free();
    for (int p = 0; p < NP; p++) if (m_st[p] == 0) return p;
    return -1;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < NP; p++) begin
      m_st[p] = (p < NA) ? 1 : 0; m_dest[p] = 0; m_prev[p] = 0;
    end
    for (int a = 0; a < NA; a++) begin
      m_spec[a] = a; m_cmt[a] = a; m_ren[a] = 1'b0;
    end
    f_cnt = 0;
  endtask

  task automatic step(bit iv, int ia, bit fv, int fp, bit cv, int cp, bit fl,
                      int s0, int s1, int qp, string qtag);
    int pk;
    bit rdy;
    @(negedge clk);
    issue_valid_i = iv; issue_arch_i = AW'(ia);
    finish_valid_i = fv; finish_phys_i = PW'(fp);
    complete_valid_i = cv; complete_phys_i = PW'(cp);
    flush_i = fl; query_phys_i = PW'(qp);
    src_arch_i = {AW'(s1), AW'(s0)};
    #1;
    pk = pick_free();
    rdy = (pk >= 0) && !fl;
    chk("R3 ready", int'(issue_ready_o), int'(rdy));
    if (rdy) chk("R2 issue_phys", int'(issue_phys_o), pk);
    chk("R2 old_phys", int'(issue_old_phys_o), m_spec[ia]);
    chk("R4 src0", int'(src_phys_o[PW-1:0]), m_spec[s0]);
    chk("R4 src1", int'(src_phys_o[2*PW-1:PW]), m_spec[s1]);
    chk("R8 ren0", int'(src_renamed_o[0]), int'(m_ren[s0]));
    chk("R8 ren1", int'(src_renamed_o[1]), int'(m_ren[s1]));
    chk(qtag, int'(query_state_o), m_st[qp]);
    @(posedge clk);
    if (fl) begin
      for (int p = 0; p < NP; p++) if (m_st[p] >= 2) m_st[p] = 0;
      for (int a = 0; a < NA; a++) begin m_spec[a] = m_cmt[a]; m_ren[a] = 1'b0; end
      f_cnt = 0;
    end else begin
      if (fv && m_st[fp] == 2) m_st[fp] = 3;
      if (cv) begin
        int d;
        d = m_dest[cp];
        m_st[cp] = 1; m_cmt[d] = cp; m_st[m_prev[cp]] = 0;
        if (m_spec[d] == cp) m_ren[d] = 1'b0;
        for (int i = 1; i < f_cnt; i++) fifo[i-1] = fifo[i];
        f_cnt--;
      end
      if (iv && rdy) begin
        m_st[pk] = 2; m_dest[pk] = ia; m_prev[pk] = m_spec[ia];
        m_spec[ia] = pk; m_ren[ia] = 1'b1;
        fifo[f_cnt] = pk; f_cnt++;
      end
    end
  endtask

  task automatic idle_q(int qp, string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, qp, tag);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset image
    for (int p = 0; p < NP; p++) idle_q(p, "R1 reset state");

    // R4 same-cycle lookup sees old mapping, next cycle sees new
    step(1, 3, 0, 0, 0, 0, 0, 3, 3, 8, "R2 pre-alloc state");
    idle_q(8, "R2 pending state");
    step(0, 0, 0, 0, 0, 0, 0, 3, 2, 8, "R4 new mapping");

    // R5 finish on non-pending registers ignored
    step(0, 0, 1, 2, 0, 0, 0, 0, 1, 2, "R5");
    idle_q(2, "R5 arch untouched");
    step(0, 0, 1, 9, 0, 0, 0, 0, 1, 9, "R5");
    idle_q(9, "R5 free untouched");
    step(0, 0, 1, 8, 0, 0, 0, 0, 1, 8, "R5");
    idle_q(8, "R5 written");

    // R6 completion retires previous instance 3
    step(0, 0, 0, 0, 1, 8, 0, 3, 3, 8, "R6");
    idle_q(3, "R6 previous freed");
    idle_q(8, "R6 now arch");

    // R3 exhaust pool, then press issue while stalled
    for (int i = 0; i < NP - NA; i++) step(1, 1, 0, 0, 0, 0, 0, 1, 0, 0, "R3");
    step(1, 2, 0, 0, 0, 0, 0, 2, 1, 2, "R3 stalled");
    idle_q(2, "R3 no change");
    step(0, 0, 0, 0, 0, 0, 0, 2, 1, 3, "R3 no change");

    // R7 flush with concurrent issue request and finish
    step(1, 5, 1, 3, 0, 0, 1, 1, 5, 3, "R7");
    for (int p = 0; p < NP; p++) idle_q(p, "R7 after flush");

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      bit iv, fv, cv, fl;
      int ia, fp, cp;
      iv = ($urandom % 100) < 45;
      ia = $urandom % NA;
      fv = ($urandom % 100) < 50;
      fp = (f_cnt > 0 && ($urandom % 4) != 0) ? fifo[$urandom % f_cnt] : ($urandom % NP);
      cv = (f_cnt > 0) && (m_st[fifo[0]] == 3) && (($urandom % 100) < 60);
      cp = (f_cnt > 0) ? fifo[0] : 0;
      fl = ($urandom % 100) < 2;
      step(iv, ia, fv, fp, cv, cp, fl, $urandom % NA, $urandom % NA,
           $urandom % NP, "R6 random state");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule